// File: doc/BRIEF.md
# Serial Input Pin Interrupt Unit

This block raises interrupts from the input pins of a serial I/O chain. The pins form `PLANES` bit-planes of `PORTS` ports each. Pin (plane b, port p) sits at bit `b*PORTS + p` of the sample vector. Whenever the chain finishes a capture, it presents the whole sample vector together with a one-cycle valid strobe. Each pin compares its new sample with the one captured at the previous strobe. A detected event sets a sticky pending bit.

Every pin has its own settings: a 2-bit trigger code, a level polarity and an enable. The trigger code is split across two banks of trigger words, one for its low bit and one for its high bit. Software reads one identity word per plane, equal to the pending bits masked by the enables. It clears pending bits through write-one-to-clear acknowledge words. A master enable gates the single combined interrupt output.

Registers are reached through a write port and a separate combinational read port. Both use a word address: group in `addr[5:3]`, word index in `addr[2:0]`.

Top module: `sio_irq_unit`

## Requirements
- R1: After reset the master enable, every per-pin enable, trigger word, polarity word and pending bit is zero, and `irq` is low.
- R2: Trigger code per pin: 0 = level, 1 = both edges, 2 = falling edge, 3 = rising edge. The code's low bit is held in trigger word b, its high bit in trigger word PLANES+b, and the bit position inside each word is the port number. Both words read back as written.
- R3: In level mode (code 0) the pending bit is set on every strobe whose sample is at the active level. Polarity 0 means active high, polarity 1 means active low.
- R4: Code 1 sets pending on a strobe whose sample differs from the previous strobe's sample of that pin. Polarity has no effect.
- R5: Code 2 sets pending on a strobe where the previous sample was 1 and the new one is 0.
- R6: Code 3 sets pending on a strobe where the previous sample was 0 and the new one is 1. Polarity has no effect on this mode.
- R7: The first strobe after reset only loads the reference sample and produces no edge event. Level mode still evaluates that strobe.
- R8: Edge detection uses only strobed samples. Changes on `sample_data` while `sample_valid` is low neither set pending nor move the reference.
- R9: Pending bits are sticky. Writing 1 to a bit of acknowledge word b clears only that pin, and bits written 0 are untouched. An event on the same cycle as its acknowledge leaves the pin pending.
- R10: Identity word b reads as pending AND enable for plane b. Pending collects while a pin is disabled, so enabling the pin later exposes it.
- R11: `irq` is high exactly when the master enable (config word 0, bit 0) is 1 and some identity bit is set.
- R12: Address groups are config=0, polarity=1, trigger=2, enable=3, acknowledge=4 and identity=5. Acknowledge words read as zero. Identity words cannot be written, and a write to them changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address: group [5:3], index [2:0] |
| wr_data | input | 32 | Write data, one bit per port |
| rd_addr | input | 6 | Read address, same layout |
| rd_data | output | 32 | Combinational read data |
| sample_valid | input | 1 | One-cycle strobe: new capture present |
| sample_data | input | 128 | Captured pin values, bit b*32+p |
| irq | output | 1 | Combined interrupt |

## Verification
A register write lands at the clock edge that samples `wr_en`, and its readback is valid from just after that edge. A strobe sampled at an edge updates the pending bits at that same edge. Identity words and `irq` are combinational from the pending flops, so they show the result just after the edge. The bench drives every input on the falling edge and checks half a cycle later, after exactly one rising edge has passed. The same-cycle acknowledge and event case is driven as a single combined falling-edge stimulus.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

    localparam int unsigned GRP_W = 3;

    typedef enum logic [GRP_W-1:0] {
        GRP_CFG   = 3'd0,
        GRP_POL   = 3'd1,
        GRP_TRIG  = 3'd2,
        GRP_ENA   = 3'd3,
        GRP_ACK   = 3'd4,
        GRP_IDENT = 3'd5
    } sio_grp_e;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'd0,
        TRIG_BOTH  = 2'd1,
        TRIG_FALL  = 2'd2,
        TRIG_RISE  = 2'd3
    } sio_trig_e;

    // Event rule for one pin, evaluated on a capture strobe.
    function automatic logic pin_event(input logic [1:0] code, input logic cur,
                                       input logic prev, input logic pol,
                                       input logic primed);
        case (code)
            TRIG_LEVEL: return cur ^ pol;
            TRIG_BOTH:  return primed & (cur ^ prev);
            TRIG_FALL:  return primed & prev & ~cur;
            default:    return primed & ~prev & cur;
        endcase
    endfunction

endpackage

// File: rtl/sio_irq_cfg.sv
module sio_irq_cfg
    import sio_irq_pkg::*;
#(
    parameter int unsigned PLANES = 4,
    parameter int unsigned PORTS  = 32,
    parameter int unsigned IDX_W  = 3,
    localparam int unsigned TOTAL = PLANES * PORTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [GRP_W-1:0] wr_grp,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PORTS-1:0] wr_data,
    output logic             master,
    output logic [TOTAL-1:0] pol,
    output logic [TOTAL-1:0] trig_lo,
    output logic [TOTAL-1:0] trig_hi,
    output logic [TOTAL-1:0] en
);

    typedef struct packed {
        logic             master;
        logic [TOTAL-1:0] pol;
        logic [TOTAL-1:0] tlo;
        logic [TOTAL-1:0] thi;
        logic [TOTAL-1:0] en;
    } cfg_t;

    cfg_t        st_d, st_q;
    int unsigned idx_u;

    assign idx_u = 32'(wr_idx);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_grp)
                GRP_CFG: begin
                    if (idx_u == 0) st_d.master = wr_data[0];
                end
                GRP_POL: begin
                    if (idx_u < PLANES) st_d.pol[idx_u*PORTS +: PORTS] = wr_data;
                end
                GRP_TRIG: begin
                    if (idx_u < PLANES)
                        st_d.tlo[idx_u*PORTS +: PORTS] = wr_data;
                    else if (idx_u < 2*PLANES)
                        st_d.thi[(idx_u-PLANES)*PORTS +: PORTS] = wr_data;
                end
                GRP_ENA: begin
                    if (idx_u < PLANES) st_d.en[idx_u*PORTS +: PORTS] = wr_data;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign master  = st_q.master;
    assign pol     = st_q.pol;
    assign trig_lo = st_q.tlo;
    assign trig_hi = st_q.thi;
    assign en      = st_q.en;

    // Enables move only on a write to the enable group.
    assert_en_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_grp == GRP_ENA) |=> $stable(st_q.en));

endmodule

// File: rtl/sio_irq_detect.sv
module sio_irq_detect
    import sio_irq_pkg::*;
#(
    parameter int unsigned PLANES = 4,
    parameter int unsigned PORTS  = 32,
    localparam int unsigned TOTAL = PLANES * PORTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_valid,
    input  logic [TOTAL-1:0] sample_data,
    input  logic [TOTAL-1:0] trig_lo,
    input  logic [TOTAL-1:0] trig_hi,
    input  logic [TOTAL-1:0] pol,
    output logic [TOTAL-1:0] evt
);

    typedef struct packed {
        logic             primed;
        logic [TOTAL-1:0] prev;
    } det_t;

    det_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sample_valid) begin
            st_d.prev   = sample_data;
            st_d.primed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < TOTAL; g++) begin : g_pin
        assign evt[g] = sample_valid &
                        pin_event({trig_hi[g], trig_lo[g]}, sample_data[g],
                                  st_q.prev[g], pol[g], st_q.primed);
    end

    // The priming strobe yields no edge-mode event.
    assert_first_strobe_no_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !st_q.primed) |-> ((evt & (trig_lo | trig_hi)) == '0));

    // No strobe, no event.
    assert_no_strobe_no_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> (evt == '0));

endmodule

// File: rtl/sio_irq_unit.sv
module sio_irq_unit
    import sio_irq_pkg::*;
#(
    parameter int unsigned PLANES = 4,
    parameter int unsigned PORTS  = 32,
    localparam int unsigned TOTAL  = PLANES * PORTS,
    localparam int unsigned IDX_W  = $clog2(2 * PLANES),
    localparam int unsigned ADDR_W = GRP_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PORTS-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [PORTS-1:0]  rd_data,
    input  logic              sample_valid,
    input  logic [TOTAL-1:0]  sample_data,
    output logic              irq
);

    typedef struct packed {
        logic [TOTAL-1:0] pend;
    } unit_t;

    unit_t            st_d, st_q;
    logic [GRP_W-1:0] wr_grp, rd_grp;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    int unsigned      wr_idx_u, rd_idx_u;
    logic             master;
    logic [TOTAL-1:0] pol, tlo, thi, en, evt, ack, ident;

    assign wr_grp   = wr_addr[ADDR_W-1 -: GRP_W];
    assign wr_idx   = wr_addr[IDX_W-1:0];
    assign rd_grp   = rd_addr[ADDR_W-1 -: GRP_W];
    assign rd_idx   = rd_addr[IDX_W-1:0];
    assign wr_idx_u = 32'(wr_idx);
    assign rd_idx_u = 32'(rd_idx);

    sio_irq_cfg #(.PLANES(PLANES), .PORTS(PORTS), .IDX_W(IDX_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_grp(wr_grp),
        .wr_idx(wr_idx), .wr_data(wr_data), .master(master), .pol(pol),
        .trig_lo(tlo), .trig_hi(thi), .en(en)
    );

    sio_irq_detect #(.PLANES(PLANES), .PORTS(PORTS)) u_detect (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .sample_data(sample_data), .trig_lo(tlo), .trig_hi(thi),
        .pol(pol), .evt(evt)
    );

    // Acknowledge mask from a write to the acknowledge group.
    always_comb begin
        ack = '0;
        if (wr_en && wr_grp == GRP_ACK && wr_idx_u < PLANES)
            ack[wr_idx_u*PORTS +: PORTS] = wr_data;
    end

    // A fresh event outranks a same-cycle acknowledge.
    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~ack) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ident = st_q.pend & en;
    assign irq   = master & (|ident);

    always_comb begin
        rd_data = '0;
        case (rd_grp)
            GRP_CFG: begin
                if (rd_idx_u == 0) rd_data[0] = master;
            end
            GRP_POL: begin
                if (rd_idx_u < PLANES) rd_data = pol[rd_idx_u*PORTS +: PORTS];
            end
            GRP_TRIG: begin
                if (rd_idx_u < PLANES)
                    rd_data = tlo[rd_idx_u*PORTS +: PORTS];
                else if (rd_idx_u < 2*PLANES)
                    rd_data = thi[(rd_idx_u-PLANES)*PORTS +: PORTS];
            end
            GRP_ENA: begin
                if (rd_idx_u < PLANES) rd_data = en[rd_idx_u*PORTS +: PORTS];
            end
            GRP_IDENT: begin
                if (rd_idx_u < PLANES) rd_data = ident[rd_idx_u*PORTS +: PORTS];
            end
            default: ;
        endcase
    end

    // Without an acknowledge write no pending bit falls.
    assert_pend_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_grp == GRP_ACK) |=>
        ((st_q.pend & $past(st_q.pend)) == $past(st_q.pend)));

    // Acknowledged bits of plane 0 are clear when no strobe coincides.
    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_grp == GRP_ACK && wr_idx == '0 && !sample_valid) |=>
        ((st_q.pend[PORTS-1:0] & $past(wr_data)) == '0));

    // Pending bits rise only on a capture strobe.
    assert_pend_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> ((st_q.pend & ~$past(st_q.pend)) == '0));

endmodule

// File: tb/sio_irq_unit_bench.sv
module sio_irq_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] G_CFG = 3'd0, G_POL = 3'd1, G_TRIG = 3'd2,
                           G_ENA = 3'd3, G_ACK = 3'd4, G_IDENT = 3'd5;
    localparam int PIN_PLANE = 1;
    localparam int PIN_PORT  = 5;

    // {trig[1:0], pol, s0, s1, s2, e0, e1, e2}
    localparam logic [8:0] VEC [9] = '{
        {2'd0, 1'b0, 3'b110, 3'b110},
        {2'd0, 1'b1, 3'b100, 3'b011},
        {2'd1, 1'b0, 3'b010, 3'b011},
        {2'd1, 1'b0, 3'b111, 3'b000},
        {2'd2, 1'b0, 3'b101, 3'b010},
        {2'd2, 1'b0, 3'b010, 3'b001},
        {2'd3, 1'b0, 3'b101, 3'b001},
        {2'd3, 1'b0, 3'b001, 3'b001},
        {2'd3, 1'b1, 3'b011, 3'b010}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [5:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [5:0]   rd_addr = '0;
    logic [31:0]  rd_data;
    logic         sample_valid = 1'b0;
    logic [127:0] sample_data = '0;
    logic         irq;
    int           n_chk = 0;
    int           n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_irq_unit u_sio_irq_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sample_valid(sample_valid), .sample_data(sample_data), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; sample_valid = 1'b0; sample_data = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] g, input int idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = {g, 3'(idx)}; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] g, input int idx,
                          input logic [31:0] exp, input string req);
        rd_addr = {g, 3'(idx)};
        #1;
        chk(req, $sformatf("read g%0d w%0d", g, idx), rd_data, exp);
    endtask

    task automatic strobe(input logic [127:0] v);
        @(negedge clk);
        sample_data = v; sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic irq_chk(input logic exp, input string req);
        #1;
        chk(req, "irq", {31'b0, irq}, {31'b0, exp});
    endtask

    function automatic string req_of(input logic [1:0] t);
        case (t)
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic logic [127:0] pin_vec(input logic b);
        logic [127:0] v = '0;
        v[PIN_PLANE*32 + PIN_PORT] = b;
        return v;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        irq_chk(1'b0, "R1");
        rd_chk(G_CFG, 0, 32'h0, "R1");
        rd_chk(G_ENA, 0, 32'h0, "R1");
        rd_chk(G_ENA, 3, 32'h0, "R1");
        rd_chk(G_TRIG, 5, 32'h0, "R1");
        rd_chk(G_POL, 2, 32'h0, "R1");
        rd_chk(G_IDENT, 1, 32'h0, "R1");

        // Table of single-pin sequences (R3..R7)
        for (int i = 0; i < 9; i++) begin
            logic [1:0] t   = VEC[i][8:7];
            logic       p   = VEC[i][6];
            logic [2:0] s   = VEC[i][5:3];
            logic [2:0] e   = VEC[i][2:0];
            string      req = req_of(t);
            do_reset();
            wr(G_TRIG, PIN_PLANE, {26'b0, t[0], 5'b0});
            wr(G_TRIG, 4 + PIN_PLANE, {26'b0, t[1], 5'b0});
            wr(G_POL, PIN_PLANE, {26'b0, p, 5'b0});
            wr(G_ENA, PIN_PLANE, 32'h20);
            wr(G_CFG, 0, 32'h1);
            strobe(pin_vec(s[2]));
            rd_chk(G_IDENT, PIN_PLANE, {26'b0, e[2], 5'b0}, (t == 2'd0) ? req : "R7");
            irq_chk(e[2], (t == 2'd0) ? req : "R7");
            wr(G_ACK, PIN_PLANE, 32'hFFFF_FFFF);
            strobe(pin_vec(s[1]));
            rd_chk(G_IDENT, PIN_PLANE, {26'b0, e[1], 5'b0}, req);
            wr(G_ACK, PIN_PLANE, 32'hFFFF_FFFF);
            strobe(pin_vec(s[0]));
            rd_chk(G_IDENT, PIN_PLANE, {26'b0, e[0], 5'b0}, req);
            irq_chk(e[0], req);
        end

        // R2 / R12: split trigger words, readback and behaviour
        do_reset();
        wr(G_TRIG, 2, 32'hA5A5_0F0F);
        wr(G_TRIG, 6, 32'h1234_5678);
        rd_chk(G_TRIG, 2, 32'hA5A5_0F0F, "R2");
        rd_chk(G_TRIG, 6, 32'h1234_5678, "R2");
        rd_chk(G_POL, 2, 32'h0, "R12");
        wr(G_ENA, 2, 32'h9);
        wr(G_CFG, 0, 32'h1);
        strobe('0);
        strobe(128'h9 << 64);
        rd_chk(G_IDENT, 2, 32'h9, "R2");
        wr(G_ACK, 2, 32'hFFFF_FFFF);
        strobe('0);
        rd_chk(G_IDENT, 2, 32'h1, "R2");

        // R8: unstrobed changes ignored
        do_reset();
        wr(G_TRIG, 0, 32'h1);
        wr(G_TRIG, 4, 32'h1);
        wr(G_ENA, 0, 32'h1);
        wr(G_CFG, 0, 32'h1);
        strobe('0);
        @(negedge clk); sample_data = 128'h1;
        repeat (3) @(negedge clk);
        sample_data = '0;
        strobe('0);
        rd_chk(G_IDENT, 0, 32'h0, "R8");
        irq_chk(1'b0, "R8");
        @(negedge clk); sample_data = 128'h1;
        repeat (2) @(negedge clk);
        strobe(128'h1);
        rd_chk(G_IDENT, 0, 32'h1, "R8");

        // R9: selective acknowledge and event-wins collision
        wr(G_TRIG, 0, 32'h3);
        wr(G_TRIG, 4, 32'h3);
        wr(G_ENA, 0, 32'h3);
        strobe(128'h3);
        rd_chk(G_IDENT, 0, 32'h3, "R9");
        wr(G_ACK, 0, 32'h1);
        rd_chk(G_IDENT, 0, 32'h2, "R9");
        strobe('0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = {G_ACK, 3'd0}; wr_data = 32'h3;
        sample_data = 128'h1; sample_valid = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; sample_valid = 1'b0;
        rd_chk(G_IDENT, 0, 32'h1, "R9");

        // R10: pending held while disabled
        wr(G_ENA, 0, 32'h0);
        rd_chk(G_IDENT, 0, 32'h0, "R10");
        irq_chk(1'b0, "R10");
        wr(G_ENA, 0, 32'h3);
        rd_chk(G_IDENT, 0, 32'h1, "R10");
        irq_chk(1'b1, "R10");

        // R11: master gating
        wr(G_CFG, 0, 32'h0);
        irq_chk(1'b0, "R11");
        rd_chk(G_CFG, 0, 32'h0, "R11");
        rd_chk(G_IDENT, 0, 32'h1, "R11");
        wr(G_CFG, 0, 32'h1);
        irq_chk(1'b1, "R11");
        rd_chk(G_CFG, 0, 32'h1, "R11");

        // R12: identity not writable, acknowledge reads zero
        wr(G_IDENT, 0, 32'h0);
        rd_chk(G_IDENT, 0, 32'h1, "R12");
        rd_chk(G_ACK, 0, 32'h0, "R12");

        // R1: reset clears everything after activity
        do_reset();
        rd_chk(G_ENA, 0, 32'h0, "R1");
        rd_chk(G_TRIG, 0, 32'h0, "R1");
        rd_chk(G_CFG, 0, 32'h0, "R1");
        wr(G_ENA, 0, 32'h3);
        wr(G_CFG, 0, 32'h1);
        rd_chk(G_IDENT, 0, 32'h0, "R1");
        irq_chk(1'b0, "R1");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule